// File: doc/BRIEF.md
# Traffic-Class Memory Port Arbiter

This block sits at the front of a memory controller. Several ports each present one pending command per cycle: a direction (read or write) and a 4-bit AXI QoS value. In each cycle the arbiter picks at most one command and passes it on toward the shared read and write command stores. Each port sorts its commands into traffic classes. The QoS value first chooses one of two regions by comparison with a per-port threshold. The region then names the class. Reads go to high, low or video. Writes go to normal or video.

The choice is made in layers, in this order:
1. Urgent ports.
2. Direction, with aged video commands able to force it.
3. Class.
4. Highest QoS.
5. A round-robin pointer.

Video commands age while they wait. Once a video command has waited its port's timeout, it ranks above everything else in its direction. Ports are throttled from the store occupancy: low-latency ports when the high-priority read entries run short, and best-effort ports when the low-priority read entries or the normal write entries run short. Video-type ports are never throttled.

The request inputs are combinational toward the grant outputs. A port holds a command until it sees its grant bit, and it may present a new command in the next cycle.

Top module: `tcarb_port_arbiter`

## Requirements
- R1: A port's QoS value that is below the port's threshold selects region 0; any other value selects region 1. The region picks the read class from a 2-bit field, or the write class from a 1-bit field. Region 0 uses the low bits of each per-port map. Read encoding: 0 low, 1 high, 2 video. Write encoding: 0 normal, 1 video. The granted class is shown on `grantClass`.
- R2: The read direction is served when an expired video read is eligible, or when any read is eligible and no expired video write is eligible. Otherwise an eligible write is served.
- R3: Among reads, high-class commands beat low-class commands and unexpired video commands. Low-class commands and unexpired video commands compete as equals at the QoS layer.
- R4: A video command's age starts at 0 when it becomes pending and rises by one per cycle it waits. The command is expired once its age reaches the port's timeout (1 to 1024). An expired video read beats high reads, and an expired video write beats normal writes. The age returns to 0 when the port is granted or has no video command pending.
- R5: Within the surviving class, the candidate with the highest QoS value wins.
- R6: Remaining ties go to the first candidate at or after the round-robin pointer, which is 0 after reset. The pointer moves to the winner plus one (modulo the port count) only when this tie layer made the decision.
- R7: If any valid request comes from a port flagged urgent, an urgent port is granted ahead of all the normal layers. Urgent ports are exempt from throttling.
- R8: Port type encoding: 0 best-effort, 1 low-latency, 2 video. A low-latency port is throttled when free high read entries are fewer than their threshold. A best-effort port is throttled when free low read entries or free normal write entries are fewer than their thresholds. A throttled port is not granted.
- R9: At most one grant bit is set per cycle, and only for a port with a valid request. `grantValid` is high exactly when some eligible request exists.
- R10: After reset, the video age counters are zero and the round-robin pointer selects port 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | N_PORTS | A command is pending on each port |
| reqIsWrite | input | N_PORTS | Direction of each pending command (1 = write) |
| reqQos | input | N_PORTS*4 | AXI QoS value of each pending command |
| cfgRegionThr | input | N_PORTS*4 | Per-port QoS threshold for region 1 |
| cfgRdClass | input | N_PORTS*4 | Per-port read class, region 0 in [1:0], region 1 in [3:2] |
| cfgWrClass | input | N_PORTS*2 | Per-port write class, region 0 in bit 0, region 1 in bit 1 |
| cfgPortType | input | N_PORTS*2 | Per-port throttle type |
| cfgUrgent | input | N_PORTS | Per-port urgent flag |
| cfgTimeout | input | N_PORTS*AGE_W | Per-port video timeout in cycles |
| hprFree | input | FREE_W | Free high-priority read store entries |
| lprFree | input | FREE_W | Free low-priority read store entries |
| npwFree | input | FREE_W | Free normal write store entries |
| hprThr | input | FREE_W | Throttle threshold for low-latency ports |
| lprThr | input | FREE_W | Read throttle threshold for best-effort ports |
| npwThr | input | FREE_W | Write throttle threshold for best-effort ports |
| grantOh | output | N_PORTS | One-hot grant, accepted by the port this cycle |
| grantValid | output | 1 | A command is granted this cycle |
| grantPort | output | IDX_W | Index of the granted port |
| grantIsWrite | output | 1 | Direction of the granted command |
| grantClass | output | 2 | Traffic class of the granted command |
| grantQos | output | 4 | QoS value of the granted command |

## Verification
The only internal state is the video age counters and the round-robin pointer. A wrong age shows up at the ports as a video command granted one or more cycles early or late, against a steady stream of high reads. A counter that fails to clear shows up as a video command beating a high read in the cycle right after its own grant. A pointer that moves at the wrong time becomes visible at the next equal-QoS tie, which then goes to the wrong port. The bench places such ties directly after grants decided by QoS, so a wrong pointer is caught at once. Class, direction and throttle errors show in the same cycle as the stimulus.

// File: rtl/tcarb_pkg.sv
package tcarb_pkg;
  localparam int QOS_W = 4;

  // read traffic classes
  localparam logic [1:0] CLS_LOW  = 2'd0;
  localparam logic [1:0] CLS_HIGH = 2'd1;
  localparam logic [1:0] CLS_VID  = 2'd2;

  // write traffic classes
  localparam logic WCLS_NORM = 1'b0;
  localparam logic WCLS_VID  = 1'b1;

  // throttle type per port
  localparam logic [1:0] PT_BEST   = 2'd0;
  localparam logic [1:0] PT_LOWLAT = 2'd1;
  localparam logic [1:0] PT_VIDEO  = 2'd2;

  // control-to-datapath strobes
  typedef struct packed {
    logic anyCand;
    logic urgentMode;
    logic pickWrite;
  } arbStrobe_t;
endpackage

// File: rtl/tcarb_classmap.sv
module tcarb_classmap
  import tcarb_pkg::*;
(
  input  logic [QOS_W-1:0] qos,
  input  logic [QOS_W-1:0] thr,
  input  logic [3:0]       rdMap,
  input  logic [1:0]       wrMap,
  input  logic             isWrite,
  output logic [1:0]       cls,
  output logic             isVideo
);
  logic       region;
  logic [1:0] rdCls;
  logic       wrCls;

  always_comb begin
    region  = (qos >= thr);
    rdCls   = region ? rdMap[3:2] : rdMap[1:0];
    wrCls   = region ? wrMap[1] : wrMap[0];
    cls     = isWrite ? {1'b0, wrCls} : rdCls;
    isVideo = isWrite ? (wrCls == WCLS_VID) : (rdCls == CLS_VID);
  end
endmodule

// File: rtl/tcarb_ctrl.sv
module tcarb_ctrl
  import tcarb_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int AGE_W   = 11,
  parameter int FREE_W  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [N_PORTS-1:0]       reqValid,
  input  logic [N_PORTS-1:0]       reqIsWrite,
  input  logic [N_PORTS*QOS_W-1:0] reqQos,
  input  logic [N_PORTS*QOS_W-1:0] cfgRegionThr,
  input  logic [N_PORTS*4-1:0]     cfgRdClass,
  input  logic [N_PORTS*2-1:0]     cfgWrClass,
  input  logic [N_PORTS*2-1:0]     cfgPortType,
  input  logic [N_PORTS-1:0]       cfgUrgent,
  input  logic [N_PORTS*AGE_W-1:0] cfgTimeout,
  input  logic [FREE_W-1:0]        hprFree,
  input  logic [FREE_W-1:0]        lprFree,
  input  logic [FREE_W-1:0]        npwFree,
  input  logic [FREE_W-1:0]        hprThr,
  input  logic [FREE_W-1:0]        lprThr,
  input  logic [FREE_W-1:0]        npwThr,
  input  logic [N_PORTS-1:0]       grantOh,
  output logic [N_PORTS-1:0]       candMask,
  output logic [N_PORTS*2-1:0]     portClass,
  output arbStrobe_t               strobe
);
  logic [N_PORTS-1:0] isVid;
  logic [N_PORTS-1:0] isHigh;
  logic [N_PORTS-1:0] throttled;
  logic [N_PORTS-1:0] expired;
  logic [N_PORTS-1:0] elig;

  logic hprShort, lprShort, npwShort;
  assign hprShort = (hprFree < hprThr);
  assign lprShort = (lprFree < lprThr);
  assign npwShort = (npwFree < npwThr);

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    logic [1:0]       cls;
    logic [1:0]       pType;
    logic [AGE_W-1:0] age;
    logic [AGE_W-1:0] limit;

    tcarb_classmap u_map (
      .qos    (reqQos[i*QOS_W +: QOS_W]),
      .thr    (cfgRegionThr[i*QOS_W +: QOS_W]),
      .rdMap  (cfgRdClass[i*4 +: 4]),
      .wrMap  (cfgWrClass[i*2 +: 2]),
      .isWrite(reqIsWrite[i]),
      .cls    (cls),
      .isVideo(isVid[i])
    );

    assign portClass[i*2 +: 2] = cls;
    assign isHigh[i] = !reqIsWrite[i] && (cls == CLS_HIGH);
    assign pType     = cfgPortType[i*2 +: 2];
    assign limit     = cfgTimeout[i*AGE_W +: AGE_W];
    assign expired[i] = (age >= limit);

    always_comb begin
      case (pType)
        PT_BEST:   throttled[i] = lprShort || npwShort;
        PT_LOWLAT: throttled[i] = hprShort;
        default:   throttled[i] = 1'b0;
      endcase
    end

    assign elig[i] = reqValid[i] && (cfgUrgent[i] || !throttled[i]);

    // age of the pending video command on this port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        age <= '0;
      end else if (grantOh[i] || !(reqValid[i] && isVid[i])) begin
        age <= '0;
      end else if (!expired[i]) begin
        age <= age + AGE_W'(1);
      end
    end
  end

  logic [N_PORTS-1:0] eligRd, eligWr, expRd, expWr, highRd, urgSet;
  logic               pickRead;

  always_comb begin
    eligRd   = elig & ~reqIsWrite;
    eligWr   = elig & reqIsWrite;
    expRd    = eligRd & isVid & expired;
    expWr    = eligWr & isVid & expired;
    highRd   = eligRd & isHigh;
    urgSet   = elig & cfgUrgent;
    pickRead = (|expRd) || ((|eligRd) && !(|expWr));
    strobe.urgentMode = |urgSet;
    strobe.pickWrite  = !pickRead;
    if (|urgSet) begin
      candMask = urgSet;
    end else if (pickRead) begin
      if (|expRd)       candMask = expRd;
      else if (|highRd) candMask = highRd;
      else              candMask = eligRd & ~highRd;
    end else begin
      candMask = (|expWr) ? expWr : eligWr;
    end
    strobe.anyCand = |candMask;
  end
endmodule

// File: rtl/tcarb_dp.sv
module tcarb_dp
  import tcarb_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  arbStrobe_t               strobe,
  input  logic [N_PORTS-1:0]       candMask,
  input  logic [N_PORTS-1:0]       reqIsWrite,
  input  logic [N_PORTS*QOS_W-1:0] reqQos,
  input  logic [N_PORTS*2-1:0]     portClass,
  output logic [N_PORTS-1:0]       grantOh,
  output logic                     grantValid,
  output logic [IDX_W-1:0]         grantPort,
  output logic                     grantIsWrite,
  output logic [1:0]               grantClass,
  output logic [QOS_W-1:0]         grantQos
);
  logic [QOS_W-1:0]   maxQos;
  logic [N_PORTS-1:0] qosSet;
  logic               multi;
  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   winIdx;
  logic               found;

  // QoS layer
  always_comb begin
    maxQos = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (candMask[i] && (reqQos[i*QOS_W +: QOS_W] > maxQos))
        maxQos = reqQos[i*QOS_W +: QOS_W];
    end
    for (int i = 0; i < N_PORTS; i++) begin
      qosSet[i] = candMask[i] && (reqQos[i*QOS_W +: QOS_W] == maxQos);
    end
    multi = ($countones(qosSet) > 1);
  end

  // round-robin layer
  always_comb begin
    winIdx = '0;
    found  = 1'b0;
    for (int k = 0; k < N_PORTS; k++) begin
      if (!found && qosSet[(int'(rrPtr) + k) % N_PORTS]) begin
        found  = 1'b1;
        winIdx = IDX_W'((int'(rrPtr) + k) % N_PORTS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.anyCand && multi) begin
      rrPtr <= (winIdx == IDX_W'(N_PORTS - 1)) ? '0 : winIdx + IDX_W'(1);
    end
  end

  always_comb begin
    grantOh = '0;
    if (strobe.anyCand) grantOh[winIdx] = 1'b1;
    grantValid   = strobe.anyCand;
    grantPort    = winIdx;
    grantIsWrite = strobe.urgentMode ? reqIsWrite[winIdx] : strobe.pickWrite;
    grantClass   = portClass[winIdx*2 +: 2];
    grantQos     = reqQos[winIdx*QOS_W +: QOS_W];
  end
endmodule

// File: rtl/tcarb_port_arbiter.sv
module tcarb_port_arbiter
  import tcarb_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int AGE_W   = 11,
  parameter int FREE_W  = 6,
  localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [N_PORTS-1:0]       reqValid,
  input  logic [N_PORTS-1:0]       reqIsWrite,
  input  logic [N_PORTS*4-1:0]     reqQos,
  input  logic [N_PORTS*4-1:0]     cfgRegionThr,
  input  logic [N_PORTS*4-1:0]     cfgRdClass,
  input  logic [N_PORTS*2-1:0]     cfgWrClass,
  input  logic [N_PORTS*2-1:0]     cfgPortType,
  input  logic [N_PORTS-1:0]       cfgUrgent,
  input  logic [N_PORTS*AGE_W-1:0] cfgTimeout,
  input  logic [FREE_W-1:0]        hprFree,
  input  logic [FREE_W-1:0]        lprFree,
  input  logic [FREE_W-1:0]        npwFree,
  input  logic [FREE_W-1:0]        hprThr,
  input  logic [FREE_W-1:0]        lprThr,
  input  logic [FREE_W-1:0]        npwThr,
  output logic [N_PORTS-1:0]       grantOh,
  output logic                     grantValid,
  output logic [IDX_W-1:0]         grantPort,
  output logic                     grantIsWrite,
  output logic [1:0]               grantClass,
  output logic [3:0]               grantQos
);
  arbStrobe_t         strobe;
  logic [N_PORTS-1:0] candMask;
  logic [N_PORTS*2-1:0] portClass;

  tcarb_ctrl #(.N_PORTS(N_PORTS), .AGE_W(AGE_W), .FREE_W(FREE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsWrite(reqIsWrite), .reqQos(reqQos),
    .cfgRegionThr(cfgRegionThr), .cfgRdClass(cfgRdClass), .cfgWrClass(cfgWrClass),
    .cfgPortType(cfgPortType), .cfgUrgent(cfgUrgent), .cfgTimeout(cfgTimeout),
    .hprFree(hprFree), .lprFree(lprFree), .npwFree(npwFree),
    .hprThr(hprThr), .lprThr(lprThr), .npwThr(npwThr),
    .grantOh(grantOh), .candMask(candMask), .portClass(portClass), .strobe(strobe)
  );

  tcarb_dp #(.N_PORTS(N_PORTS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .candMask(candMask),
    .reqIsWrite(reqIsWrite), .reqQos(reqQos), .portClass(portClass),
    .grantOh(grantOh), .grantValid(grantValid), .grantPort(grantPort),
    .grantIsWrite(grantIsWrite), .grantClass(grantClass), .grantQos(grantQos)
  );
endmodule

// File: rtl/tcarb_port_arbiter_chk.sv
module tcarb_port_arbiter_chk
  import tcarb_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int FREE_W  = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [N_PORTS-1:0]   reqValid,
  input logic [N_PORTS-1:0]   cfgUrgent,
  input logic [N_PORTS*2-1:0] cfgPortType,
  input logic [FREE_W-1:0]    hprFree,
  input logic [FREE_W-1:0]    hprThr,
  input logic [N_PORTS-1:0]   grantOh,
  input logic                 grantValid
);
  logic [N_PORTS-1:0] vidPort;
  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    assign vidPort[i] = (cfgPortType[i*2 +: 2] == PT_VIDEO);

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      grantOh[i] |-> reqValid[i]); // R9

    AST_LOWLAT_THROTTLE: assert property (@(posedge clk) disable iff (!rstN)
      (grantOh[i] && (cfgPortType[i*2 +: 2] == PT_LOWLAT) && !cfgUrgent[i])
        |-> (hprFree >= hprThr)); // R8
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh)); // R9

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (|grantOh)); // R9

  AST_VIDEO_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqValid & vidPort)) |-> grantValid); // R8

  AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqValid & cfgUrgent)) |-> (|(grantOh & cfgUrgent))); // R7
endmodule

bind tcarb_port_arbiter tcarb_port_arbiter_chk #(.N_PORTS(N_PORTS), .FREE_W(FREE_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgUrgent(cfgUrgent),
  .cfgPortType(cfgPortType), .hprFree(hprFree), .hprThr(hprThr),
  .grantOh(grantOh), .grantValid(grantValid)
);

// File: tb/tcarb_port_arbiter_tb.sv
module tcarb_port_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 11;
  localparam int FW = 6;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]    reqValid = '0, reqIsWrite = '0, cfgUrgent = '0;
  logic [NP*4-1:0]  reqQos = '0, cfgRegionThr, cfgRdClass;
  logic [NP*2-1:0]  cfgWrClass, cfgPortType;
  logic [NP*AW-1:0] cfgTimeout;
  logic [FW-1:0]    hprFree, lprFree, npwFree, hprThr, lprThr, npwThr;
  logic [NP-1:0]    grantOh;
  logic             grantValid, grantIsWrite;
  logic [1:0]       grantPort, grantClass;
  logic [3:0]       grantQos;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcarb_port_arbiter #(.N_PORTS(NP), .AGE_W(AW), .FREE_W(FW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite), .reqQos(reqQos),
    .cfgRegionThr(cfgRegionThr), .cfgRdClass(cfgRdClass), .cfgWrClass(cfgWrClass),
    .cfgPortType(cfgPortType), .cfgUrgent(cfgUrgent), .cfgTimeout(cfgTimeout),
    .hprFree(hprFree), .lprFree(lprFree), .npwFree(npwFree),
    .hprThr(hprThr), .lprThr(lprThr), .npwThr(npwThr),
    .grantOh(grantOh), .grantValid(grantValid), .grantPort(grantPort),
    .grantIsWrite(grantIsWrite), .grantClass(grantClass), .grantQos(grantQos)
  );

  typedef struct {
    bit    v;
    int    port;
    bit    wr;
    int    cls;
    string tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // scoreboard monitor: one expected item per driven cycle
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        exp_t e;
        bit bad;
        e = expQ.pop_front();
        checks++;
        bad = (grantValid !== e.v);
        if (e.v && !bad)
          bad = (int'(grantPort) != e.port) || (grantIsWrite !== e.wr) || (int'(grantClass) != e.cls);
        if (bad) begin
          fails++;
          $display("FAIL %s: got valid=%0d port=%0d wr=%0d cls=%0d, expected valid=%0d port=%0d wr=%0d cls=%0d",
                   e.tag, grantValid, grantPort, grantIsWrite, grantClass, e.v, e.port, e.wr, e.cls);
        end
      end
    end
  end

  task automatic expect_grant(bit v, int p, bit wr, int c, string tag);
    expQ.push_back('{v, p, wr, c, tag});
  endtask

  task automatic clr();
    reqValid = '0;
    reqIsWrite = '0;
    reqQos = '0;
  endtask

  task automatic req(int p, bit wr, int q);
    reqValid[p] = 1'b1;
    reqIsWrite[p] = wr;
    reqQos[p*4 +: 4] = 4'(q);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: got running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      cfgRegionThr[p*4 +: 4] = 4'd8;
      cfgRdClass[p*4 +: 4]   = 4'b01_00;   // region0 low, region1 high
      cfgWrClass[p*2 +: 2]   = 2'b00;
      cfgPortType[p*2 +: 2]  = 2'd1;       // low-latency
      cfgTimeout[p*AW +: AW] = 11'd4;
    end
    hprFree = 6'd32; lprFree = 6'd32; npwFree = 6'd32;
    hprThr = 6'd0; lprThr = 6'd0; npwThr = 6'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    @(negedge clk); clr(); expect_grant(0, 0, 0, 0, "R10 idle after reset");
    @(negedge clk); clr(); for (int p = 0; p < NP; p++) req(p, 0, 3);
    expect_grant(1, 0, 0, 0, "R10 rr pointer starts at port0");
    @(negedge clk); expect_grant(1, 1, 0, 0, "R6 rr advances to port1");
    @(negedge clk); expect_grant(1, 2, 0, 0, "R6 rr advances to port2");
    @(negedge clk); clr(); req(0, 0, 12); req(1, 0, 9);
    expect_grant(1, 0, 0, 1, "R5 higher qos wins in class");
    @(negedge clk); clr(); req(0, 0, 3); req(1, 0, 3);
    expect_grant(1, 0, 0, 0, "R6 pointer held after qos decision");
    @(negedge clk); clr(); req(2, 0, 7); expect_grant(1, 2, 0, 0, "R1 qos below thr region0 low");
    @(negedge clk); clr(); req(2, 0, 8); expect_grant(1, 2, 0, 1, "R1 qos at thr region1 high");
    @(negedge clk); clr(); cfgRegionThr[4 +: 4] = 4'd15; req(1, 0, 14); req(0, 0, 9);
    expect_grant(1, 0, 0, 1, "R3 high beats low of higher qos");
    @(negedge clk); clr(); cfgRegionThr[4 +: 4] = 4'd8; req(0, 1, 5); req(1, 0, 2);
    expect_grant(1, 1, 0, 0, "R2 reads before normal writes");
    @(negedge clk); clr(); req(0, 1, 5); expect_grant(1, 0, 1, 0, "R2 write when no reads");
    @(negedge clk); clr(); cfgWrClass[4 +: 2] = 2'b10; req(2, 1, 9);
    expect_grant(1, 2, 1, 1, "R1 write region1 video class");
    @(negedge clk); clr(); cfgWrClass[4 +: 2] = 2'b00;
    cfgRdClass[12 +: 4] = 4'b01_10; req(3, 0, 5); req(1, 0, 3);
    expect_grant(1, 3, 0, 2, "R3 unexpired video equal to low");
    @(negedge clk); clr(); expect_grant(0, 0, 0, 0, "R9 idle no grant");

    // video read expiry, timeout 3
    cfgTimeout[3*AW +: AW] = 11'd3;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); clr(); req(3, 0, 2); req(0, 0, 9);
      expect_grant(1, 0, 0, 1, "R4 high wins before video expiry");
    end
    @(negedge clk); expect_grant(1, 3, 0, 2, "R4 expired video read beats high");
    @(negedge clk); expect_grant(1, 0, 0, 1, "R4 age cleared after grant");
    @(negedge clk); clr(); expect_grant(0, 0, 0, 0, "R9 idle no grant");

    // video write expiry
    cfgWrClass[6 +: 2] = 2'b01;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); clr(); req(3, 1, 2); req(0, 0, 9);
      expect_grant(1, 0, 0, 1, "R2 reads while video write young");
    end
    @(negedge clk); expect_grant(1, 3, 1, 1, "R4 expired video write takes direction");
    @(negedge clk); clr(); cfgWrClass[6 +: 2] = 2'b00; cfgRdClass[12 +: 4] = 4'b01_00;
    expect_grant(0, 0, 0, 0, "R9 idle no grant");

    // urgent and throttling
    @(negedge clk); clr(); cfgPortType[2 +: 2] = 2'd0; cfgUrgent[1] = 1'b1;
    lprFree = 6'd0; lprThr = 6'd4; req(0, 0, 12); req(1, 1, 0);
    expect_grant(1, 1, 1, 0, "R7 urgent throttled port served first");
    @(negedge clk); cfgUrgent[1] = 1'b0;
    expect_grant(1, 0, 0, 1, "R8 best-effort blocked without urgent");
    @(negedge clk); clr(); req(1, 0, 3); expect_grant(0, 0, 0, 0, "R8 best-effort read throttled");
    @(negedge clk); clr(); lprFree = 6'd32; npwFree = 6'd1; npwThr = 6'd4; req(1, 1, 3);
    expect_grant(0, 0, 0, 0, "R8 best-effort write throttled");
    @(negedge clk); clr(); npwFree = 6'd32; hprFree = 6'd2; hprThr = 6'd4; req(0, 0, 12);
    expect_grant(0, 0, 0, 0, "R8 low-latency throttled");
    @(negedge clk); cfgPortType[4 +: 2] = 2'd2; req(2, 0, 1);
    expect_grant(1, 2, 0, 0, "R8 video port never throttled");
    @(negedge clk); clr(); hprFree = 6'd32; req(0, 0, 12);
    expect_grant(1, 0, 0, 1, "R8 low-latency released");

    @(negedge clk); clr();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule